// File: doc/BRIEF.md
# Rate-Selectable Sinc1 Decimation Filter

This block turns a one-bit delta-sigma modulator stream into signed conversion words. It counts the ones that arrive while the modulator enable is high, over a window whose length is set by a two-bit rate select. At the end of each window it turns the count into a bipolar two's complement value. It clips that value to the range of the resolution tied to the rate, and presents it right-justified and sign-extended in a 16-bit word, together with a single-clock valid strobe.

A longer window gives a slower output rate and more bits of resolution. With a nominal modulator rate of about 262 kHz, the four selects give roughly 128, 32, 16 and 8 results per second. A start/clear strobe throws away the window in progress and opens a fresh one at the rate presented in that cycle. This lets a host switch rate without waiting for the old window to finish.

Top module: `sinc_decim`

## Requirements
- R1: Synchronous reset drives `result` to 0000h and `resultValid` to 0, and empties the ones count and the window position.
- R2: A window spans exactly 2048, 8192, 16384 or 32768 enabled modulator bits for `rateSel` 00, 01, 10 or 11. `result` and `resultValid` update at the clock edge that samples the window's last enabled bit, and at no earlier edge.
- R3: A clock in which `modBitEn` is low neither advances the window nor adds to the count, whatever `modBit` holds.
- R4: With resolution n of 12, 14, 15 or 16 bits for `rateSel` 00, 01, 10 or 11, a window of length 2^(n-1) holding k ones yields the value 2k - 2^(n-1).
- R5: A value above 2^(n-1)-1 is clipped to 2^(n-1)-1. An all-ones window therefore reads 07FFh, 1FFFh, 3FFFh or 7FFFh, and an all-zeros window reads the minimum code -2^(n-1): F800h, E000h, C000h or 8000h.
- R6: The n-bit code sits in bits n-1..0 of `result`, and all bits above bit n-1 repeat its sign bit.
- R7: `resultValid` is high for exactly one clock per completed window. `result` holds its value until the next window completes.
- R8: A change of `rateSel` in the middle of a window does not alter that window's length. The new rate applies from the next window on.
- R9: `clrStart` high discards the partial window, including any bit enabled in that same clock. It starts a new window at the `rateSel` value of that clock, leaves `result` unchanged, and produces no valid.
- R10: Reset also loads the window rate from `rateSel` in the reset clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modBit | input | 1 | Modulator output bit |
| modBitEn | input | 1 | Qualifies `modBit` for this clock |
| rateSel | input | 2 | Rate / resolution select, sampled at window boundaries, clear and reset |
| clrStart | input | 1 | Abandon the current window and start a new one |
| result | output | 16 | Clipped, sign-extended conversion result |
| resultValid | output | 1 | One-clock strobe marking a new result |

## Verification
The assertions assume that every select gives a window of at least two enabled bits, so a valid can never be followed directly by another. They also assume that `rateSel` is a settled two-bit value whenever it is sampled. The stimulus changes inputs only on the falling edge, sets `rateSel` either before a clear or reset or in the middle of a window, and never drives unknown values on the modulator pins. The ones counts are chosen to land on both clip limits, close to zero on either side, and, with idle gaps inserted, on counts that would be wrong if a gated bit were counted.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  // Strobes and rate handed from the window control to the datapath.
  typedef struct packed {
    logic       clear;  // discard the partial window
    logic       accum;  // an enabled bit enters the count
    logic       dump;   // this enabled bit closes the window
    logic [1:0] rate;   // rate in force for the open window
  } winCtlT;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sinc_ctrl.sv
module sinc_ctrl
  import sinc_pkg::*;
#(
  parameter int RES0  = 12,
  parameter int RES1  = 14,
  parameter int RES2  = 15,
  parameter int RES3  = 16,
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       modBitEn,
  input  logic [1:0] rateSel,
  input  logic       clrStart,
  output winCtlT     ctlOut
);

  localparam int RES_TAB [4] = '{RES0, RES1, RES2, RES3};

  logic [CNT_W-1:0] lastIdx [4];
  logic [CNT_W-1:0] winCnt;
  logic [1:0]       activeRate;
  logic             atLast;

  // Index of the last bit of each window (window = 2^(res-1) bits).
  for (genvar g = 0; g < 4; g++) begin : g_lastIdx
    assign lastIdx[g] = CNT_W'((1 << (RES_TAB[g] - 1)) - 1);
  end

  assign atLast = (winCnt == lastIdx[activeRate]);

  always_comb begin
    ctlOut.clear = clrStart;
    ctlOut.accum = modBitEn & ~clrStart;
    ctlOut.dump  = modBitEn & ~clrStart & atLast;
    ctlOut.rate  = activeRate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt     <= '0;
      activeRate <= rateSel;
    end else if (ctlOut.clear || ctlOut.dump) begin
      winCnt     <= '0;
      activeRate <= rateSel;
    end else if (ctlOut.accum) begin
      winCnt <= winCnt + CNT_W'(1);
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    winCnt <= lastIdx[activeRate]);  // R2

  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(clrStart || (modBitEn && atLast)) |=> $stable(activeRate));  // R8

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!modBitEn && !clrStart) |=> $stable(winCnt));  // R3

endmodule

// File: rtl/sinc_scale_clip.sv
module sinc_scale_clip #(
  parameter int RES0  = 12,
  parameter int RES1  = 14,
  parameter int RES2  = 15,
  parameter int RES3  = 16,
  parameter int ACC_W = 16,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] onesCount,
  input  logic [1:0]       rateIdx,
  output logic [OUT_W-1:0] codeOut
);

  localparam int SW = ACC_W + 2;
  localparam int RES_TAB [4] = '{RES0, RES1, RES2, RES3};

  logic signed [SW-1:0] lenTab [4];
  logic signed [SW-1:0] maxTab [4];
  logic signed [SW-1:0] minTab [4];
  logic signed [SW-1:0] scaled;
  logic signed [SW-1:0] clipped;

  for (genvar g = 0; g < 4; g++) begin : g_limits
    assign lenTab[g] = SW'(1 << (RES_TAB[g] - 1));
    assign maxTab[g] = lenTab[g] - SW'(1);
    assign minTab[g] = -lenTab[g];
  end

  always_comb begin
    // 2*count - window: bipolar, full scale equals the code range
    scaled = $signed({1'b0, onesCount, 1'b0}) - lenTab[rateIdx];
    if (scaled > maxTab[rateIdx])
      clipped = maxTab[rateIdx];
    else if (scaled < minTab[rateIdx])
      clipped = minTab[rateIdx];
    else
      clipped = scaled;
    codeOut = OUT_W'(clipped);
  end

endmodule

// File: rtl/sinc_dp.sv
module sinc_dp
  import sinc_pkg::*;
#(
  parameter int RES0  = 12,
  parameter int RES1  = 14,
  parameter int RES2  = 15,
  parameter int RES3  = 16,
  parameter int ACC_W = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modBit,
  input  winCtlT           ctlIn,
  output logic [OUT_W-1:0] result,
  output logic             resultValid
);

  logic [ACC_W-1:0] onesAcc;
  logic [ACC_W-1:0] finalOnes;
  logic [OUT_W-1:0] code;

  assign finalOnes = onesAcc + ACC_W'(modBit);

  sinc_scale_clip #(
    .RES0(RES0), .RES1(RES1), .RES2(RES2), .RES3(RES3),
    .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_clip (
    .onesCount(finalOnes),
    .rateIdx  (ctlIn.rate),
    .codeOut  (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      onesAcc <= '0;
    end else if (ctlIn.clear || ctlIn.dump) begin
      onesAcc <= '0;
    end else if (ctlIn.accum) begin
      onesAcc <= finalOnes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctlIn.dump;
      if (ctlIn.dump) result <= code;
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    onesAcc < ACC_W'(1 << (ACC_W - 1)));  // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);  // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctlIn.dump |=> $stable(result));  // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ctlIn.clear |=> (onesAcc == '0) && !resultValid);  // R9

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int RES0  = 12,
  parameter int RES1  = 14,
  parameter int RES2  = 15,
  parameter int RES3  = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modBit,
  input  logic             modBitEn,
  input  logic [1:0]       rateSel,
  input  logic             clrStart,
  output logic [OUT_W-1:0] result,
  output logic             resultValid
);

  localparam int MAX_RES = maxOf4(RES0, RES1, RES2, RES3);
  localparam int CNT_W   = MAX_RES - 1;
  localparam int ACC_W   = MAX_RES;

  winCtlT winCtl;

  sinc_ctrl #(
    .RES0(RES0), .RES1(RES1), .RES2(RES2), .RES3(RES3), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modBitEn(modBitEn),
    .rateSel (rateSel),
    .clrStart(clrStart),
    .ctlOut  (winCtl)
  );

  sinc_dp #(
    .RES0(RES0), .RES1(RES1), .RES2(RES2), .RES3(RES3),
    .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .modBit     (modBit),
    .ctlIn      (winCtl),
    .result     (result),
    .resultValid(resultValid)
  );

endmodule

// File: tb/sinc_decim_bench.sv
module sinc_decim_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modBit = 1'b0;
  logic        modBitEn = 1'b0;
  logic [1:0]  rateSel = 2'b00;
  logic        clrStart = 1'b0;
  logic [15:0] result;
  logic        resultValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit armed = 1'b0;

  // behavioural reference state
  int          mCnt = 0;
  int          mOnes = 0;
  int          mRate = 0;
  logic [15:0] mRes = '0;
  bit          mVal = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sinc_decim u_sinc_decim (
    .clk(clk), .rst(rst), .modBit(modBit), .modBitEn(modBitEn),
    .rateSel(rateSel), .clrStart(clrStart),
    .result(result), .resultValid(resultValid)
  );

  function automatic int resOf(input int sel);
    case (sel)
      0: return 12;
      1: return 14;
      2: return 15;
      default: return 16;
    endcase
  endfunction

  function automatic int winOf(input int sel);
    return 1 << (resOf(sel) - 1);
  endfunction

  function automatic logic [15:0] expCode(input int ones, input int sel);
    int len;
    int v;
    len = winOf(sel);
    v = 2 * ones - len;
    if (v > len - 1) v = len - 1;
    if (v < -len) v = -len;
    return v[15:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; mOnes = 0; mRes = '0; mVal = 1'b0; mRate = int'(rateSel);
    end else if (clrStart) begin
      mCnt = 0; mOnes = 0; mVal = 1'b0; mRate = int'(rateSel);
    end else if (modBitEn) begin
      mOnes += int'(modBit);
      mCnt++;
      if (mCnt == winOf(mRate)) begin
        mRes = expCode(mOnes, mRate);
        mVal = 1'b1;
        mCnt = 0; mOnes = 0; mRate = int'(rateSel);
      end else begin
        mVal = 1'b0;
      end
    end else begin
      mVal = 1'b0;
    end
  end

  // per-clock comparison against the reference (R4, R7)
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (result !== mRes || resultValid !== mVal) begin
        failures++;
        $display("FAIL R7 per-clock: result=%h valid=%b expected result=%h valid=%b",
                 result, resultValid, mRes, mVal);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles >= 195000) begin
      failures++;
      $display("FAIL R2 watchdog: cycles=%0d expected below 195000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic checkWord(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Feed n enabled bits; the first `ones` are 1. Optional idle gaps with modBit=1.
  task automatic feed(input int n, input int ones, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 2)) begin
        modBitEn = 1'b0;
        modBit   = 1'b1;
        @(negedge clk);
      end
      modBitEn = 1'b1;
      modBit   = (i < ones);
      @(negedge clk);
    end
    modBitEn = 1'b0;
    modBit   = 1'b0;
  endtask

  task automatic pulseClr(input bit withBit);
    clrStart = 1'b1;
    modBitEn = withBit;
    modBit   = 1'b1;
    @(negedge clk);
    clrStart = 1'b0;
    modBitEn = 1'b0;
    modBit   = 1'b0;
  endtask

  initial begin
    rateSel = 2'b00;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    armed = 1'b1;
    rst = 1'b0;
    checkWord("R1 reset result", result, 16'h0000);
    checkBit("R1 reset valid", resultValid, 1'b0);

    feed(2048, 2048, 1'b0);
    checkBit("R2 valid at 2048th bit", resultValid, 1'b1);
    checkWord("R5 12-bit all ones", result, 16'h07FF);
    @(negedge clk);
    checkBit("R7 valid single clock", resultValid, 1'b0);
    checkWord("R7 result held", result, 16'h07FF);

    feed(2048, 0, 1'b0);
    checkWord("R5 R6 12-bit all zeros", result, 16'hF800);

    feed(2048, 1025, 1'b1);
    checkWord("R3 R4 gated bits ignored", result, 16'h0002);

    feed(2048, 1023, 1'b0);
    checkWord("R6 small negative extended", result, 16'hFFFE);

    feed(100, 100, 1'b0);
    rateSel = 2'b01;
    feed(1947, 0, 1'b0);
    checkBit("R8 no early valid", resultValid, 1'b0);
    feed(1, 0, 1'b0);
    checkBit("R8 old length kept", resultValid, 1'b1);
    checkWord("R8 old-rate result", result, 16'hF8C8);

    feed(2048, 0, 1'b0);
    checkBit("R2 14-bit window not done at 2048", resultValid, 1'b0);
    feed(6144, 4099, 1'b0);
    checkBit("R2 14-bit window done at 8192", resultValid, 1'b1);
    checkWord("R4 14-bit result", result, 16'h0006);

    rateSel = 2'b11;
    pulseClr(1'b0);
    checkWord("R9 clear keeps result", result, 16'h0006);
    checkBit("R9 clear gives no valid", resultValid, 1'b0);
    feed(32768, 32768, 1'b0);
    checkWord("R5 16-bit all ones", result, 16'h7FFF);

    rateSel = 2'b10;
    pulseClr(1'b0);
    feed(16384, 0, 1'b0);
    checkWord("R5 15-bit all zeros", result, 16'hC000);

    rateSel = 2'b00;
    pulseClr(1'b0);
    feed(500, 500, 1'b0);
    pulseClr(1'b1);
    feed(2048, 0, 1'b0);
    checkBit("R9 fresh window length", resultValid, 1'b1);
    checkWord("R9 partial window discarded", result, 16'hF800);

    rateSel = 2'b01;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkWord("R1 second reset result", result, 16'h0000);
    feed(2048, 2048, 1'b0);
    checkBit("R10 reset loaded new rate", resultValid, 1'b0);
    feed(6144, 6144, 1'b0);
    checkWord("R10 R5 14-bit all ones", result, 16'h1FFF);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule